// File: doc/BRIEF.md
# Hough Reference-Rho Block Walker

This block walks an image that has been cut into square pixel blocks and, for one run-time angle, produces the Hough distance (rho) of the reference pixel of every nonzero block. It uses no per-pixel multiplier. Instead, two accumulators track rho. A row register holds the rho of the first block of the current block-row. A column register moves along the row and gives one reference rho per nonzero block.

The caller loads two fixed-point angle terms with a start pulse: the block size times cos theta and the block size times sin theta. Both are computed outside the block. The caller then feeds a stream of step entries. Each entry gives the distance, in blocks, from the previous nonzero block to the next one, so zero blocks are jumped over in a single cycle. A row-end flag closes each block-row. A last-row flag on the final row-end raises a done flag.

Rho is a 20-bit two's-complement value with 12 integer bits and 8 fraction bits. It is also given split into its integer part and its fraction part, for the vote-offset logic downstream.

Top module: `hough_ref_rho`

## Requirements
- R1: While reset is held low, and on the first cycle after it, `rho_valid` and `done` are 0 and `rho_out` is 0.
- R2: A start pulse clears both accumulators to rho 0. It also captures `cfg_cos_n` and `cfg_sin_n`.
- R3: A step entry accepted in the middle of a row sets `rho_out` one cycle later to the previous `rho_out` plus k times the captured cosine term. A step of 0 leaves `rho_out` unchanged.
- R4: The first step entry after a start or a row-end takes the row register as its base. Its result is the row register plus k times the captured cosine term.
- R5: Each accepted row-end adds the captured sine term to the row register once. A step given in the same cycle as a row-end still uses the old base.
- R6: Changes to `cfg_cos_n` or `cfg_sin_n` between start pulses have no effect on any result.
- R7: `rho_int` always equals bits 19:8 of `rho_out`, and `rho_frac` equals bits 7:0.
- R8: A row-end with `last_row` high sets `done` one cycle later. While `done` is set, step entries produce no valid output and row-ends are ignored, until the next start.
- R9: `rho_valid` is high for exactly one cycle per accepted step entry, in the cycle after that entry, and is low otherwise.
- R10: All sums wrap modulo 2^20.
- R11: A start pulse takes priority over a step or row-end in the same cycle. That step or row-end is dropped.
- R12: Step values k from 0 to 8 are supported, in a 4-bit field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a new image; clear accumulators, capture angle terms |
| cfg_cos_n | input | 20 | Block size times cos theta, signed Q12.8 |
| cfg_sin_n | input | 20 | Block size times sin theta, signed Q12.8 |
| step_valid | input | 1 | A step entry is present this cycle |
| step_k | input | 4 | Blocks to advance to the next nonzero block (0 to 8) |
| row_end | input | 1 | Current block-row is finished |
| last_row | input | 1 | Qualifies `row_end` as the last block-row |
| rho_valid | output | 1 | `rho_out` holds a new reference rho |
| rho_out | output | 20 | Reference rho, signed Q12.8 |
| rho_int | output | 12 | Integer part of `rho_out` |
| rho_frac | output | 8 | Fraction part of `rho_out` |
| done | output | 1 | Last block-row has been processed |

## Verification
Every result of this block is due exactly one clock edge after the input that causes it:
- a reference rho and its valid flag appear after the edge that accepts the step;
- the new row base is already in use by the first step driven after a row-end;
- `done` rises after the edge that sees the last row-end.

The bench drives inputs on the falling edge and advances a behavioural integer model at the rising edge. It then compares every output a short delay later, in every cycle, so each result is checked in the cycle it is due. Cycles with no step must show `rho_valid` low.

// File: rtl/hough_rho_pkg.sv
// Shared types for the reference-rho walker.
// Assumes rho is signed Q12.8 fixed point and that steps never exceed MAX_STEP blocks.
package hough_rho_pkg;
    localparam int RHO_INT_W  = 12;
    localparam int RHO_FRAC_W = 8;
    localparam int RHO_W      = RHO_INT_W + RHO_FRAC_W;
    localparam int MAX_STEP   = 8;
    localparam int STEP_W     = $clog2(MAX_STEP + 1);

    typedef logic signed [RHO_W-1:0] rho_t;
    typedef logic [STEP_W-1:0]       step_t;
endpackage

// File: rtl/rho_step_table.sv
// Table of step multiples 0..MAX_STEP times the cosine term, captured on start.
// Assumes a step index above MAX_STEP selects 0 (no advance).
module rho_step_table
    import hough_rho_pkg::*;
#(
    parameter int N_STEP = MAX_STEP
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  rho_t  cos_i,
    input  step_t k_i,
    output rho_t  add_o
);
    rho_t mult_q [0:N_STEP];

    generate
        for (genvar g = 0; g <= N_STEP; g++) begin : g_entry
            // Capture g times the cosine term when a new image starts.
            always_ff @(posedge clk) begin
                if (!rst_n)    mult_q[g] <= '0;
                else if (load) mult_q[g] <= cos_i * rho_t'(g);
            end
        end
    endgenerate

    // Select the multiple that matches the requested step.
    always_comb begin
        add_o = '0;
        if (int'(k_i) <= N_STEP) add_o = mult_q[k_i];
    end
endmodule

// File: rtl/rho_row_ctrl.sv
// Control flags of the walk: row-start marker, done flag and output valid.
// Assumes start has priority over step and row-end inputs in the same cycle.
module rho_row_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic step_valid,
    input  logic row_end,
    input  logic last_row,
    output logic accept_step,
    output logic adv_row,
    output logic row_first,
    output logic done,
    output logic valid
);
    // Decide which inputs take effect this cycle.
    always_comb begin
        accept_step = step_valid && !start && !done;
        adv_row     = row_end && !start && !done;
    end

    // Track whether the next step starts a fresh block-row.
    always_ff @(posedge clk) begin
        if (!rst_n)           row_first <= 1'b1;
        else if (start)       row_first <= 1'b1;
        else if (adv_row)     row_first <= 1'b1;
        else if (accept_step) row_first <= 1'b0;
    end

    // Raise done after the last row-end; clear it on start.
    always_ff @(posedge clk) begin
        if (!rst_n)                   done <= 1'b0;
        else if (start)               done <= 1'b0;
        else if (adv_row && last_row) done <= 1'b1;
    end

    // One valid pulse per accepted step.
    always_ff @(posedge clk) begin
        if (!rst_n) valid <= 1'b0;
        else        valid <= accept_step;
    end
endmodule

// File: rtl/rho_accum.sv
// The column and row accumulators that produce reference rho without multipliers.
// Assumes step_add already holds k times the captured cosine term.
module rho_accum
    import hough_rho_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  rho_t cfg_sin,
    input  logic accept_step,
    input  logic adv_row,
    input  logic row_first,
    input  rho_t step_add,
    output rho_t col_o
);
    rho_t col_q;
    rho_t row_q;
    rho_t sin_q;
    rho_t base;

    // The base is the row register at a row start, otherwise the column register.
    always_comb base = row_first ? row_q : col_q;

    // Column register: jump to the next nonzero block.
    always_ff @(posedge clk) begin
        if (!rst_n)           col_q <= '0;
        else if (start)       col_q <= '0;
        else if (accept_step) col_q <= base + step_add;
    end

    // Row register and captured sine term: advance one block-row per row-end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            sin_q <= '0;
        end else if (start) begin
            row_q <= '0;
            sin_q <= cfg_sin;
        end else if (adv_row) begin
            row_q <= row_q + sin_q;
        end
    end

    assign col_o = col_q;
endmodule

// File: rtl/hough_ref_rho.sv
// Top of the reference-rho walker: step table, control and accumulators.
// Assumes step entries and row-ends arrive in raster order of block-rows.
module hough_ref_rho
    import hough_rho_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic signed [RHO_W-1:0]  cfg_cos_n,
    input  logic signed [RHO_W-1:0]  cfg_sin_n,
    input  logic                     step_valid,
    input  logic [STEP_W-1:0]        step_k,
    input  logic                     row_end,
    input  logic                     last_row,
    output logic                     rho_valid,
    output logic signed [RHO_W-1:0]  rho_out,
    output logic [RHO_INT_W-1:0]     rho_int,
    output logic [RHO_FRAC_W-1:0]    rho_frac,
    output logic                     done
);
    logic accept_step;
    logic adv_row;
    logic row_first;
    rho_t step_add;

    rho_step_table #(.N_STEP(MAX_STEP)) i_table (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start),
        .cos_i (cfg_cos_n),
        .k_i   (step_k),
        .add_o (step_add)
    );

    rho_row_ctrl i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .step_valid  (step_valid),
        .row_end     (row_end),
        .last_row    (last_row),
        .accept_step (accept_step),
        .adv_row     (adv_row),
        .row_first   (row_first),
        .done        (done),
        .valid       (rho_valid)
    );

    rho_accum i_accum (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .cfg_sin     (cfg_sin_n),
        .accept_step (accept_step),
        .adv_row     (adv_row),
        .row_first   (row_first),
        .step_add    (step_add),
        .col_o       (rho_out)
    );

    // Split rho into integer and fraction parts for vote-offset logic.
    assign rho_int  = rho_out[RHO_W-1:RHO_FRAC_W];
    assign rho_frac = rho_out[RHO_FRAC_W-1:0];
endmodule

// File: rtl/hough_ref_rho_chk.sv
// Temporal checks on the reference-rho walker, bound to its top module.
module hough_ref_rho_chk
    import hough_rho_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input logic  start,
    input logic  step_valid,
    input step_t step_k,
    input logic  row_end,
    input logic  rho_valid,
    input rho_t  rho_out,
    input logic  done,
    input logic  row_first
);
    // R9: no step entry means no valid output.
    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !step_valid |=> !rho_valid);

    // R8: while done is set, no result is produced.
    p_done_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !rho_valid);

    // R8: done stays set until the next start.
    p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done);

    // R11: start wins over any step or row-end in the same cycle.
    p_start_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done && !rho_valid && row_first);

    // R3: a zero step in the middle of a row leaves rho unchanged.
    p_zero_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid && step_k == '0 && !start && !done && !row_first
        |=> rho_out == $past(rho_out));

    // R4: an accepted row-end re-arms the row base for the next step.
    p_row_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        row_end && !start && !done |=> row_first);
endmodule

bind hough_ref_rho hough_ref_rho_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .step_valid (step_valid),
    .step_k     (step_k),
    .row_end    (row_end),
    .rho_valid  (rho_valid),
    .rho_out    (rho_out),
    .done       (done),
    .row_first  (row_first)
);

// File: tb/test_hough_ref_rho.sv
module test_hough_ref_rho;
    localparam int W = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic signed [W-1:0] cfg_cos_n = '0;
    logic signed [W-1:0] cfg_sin_n = '0;
    logic step_valid = 1'b0;
    logic [3:0] step_k = '0;
    logic row_end = 1'b0;
    logic last_row = 1'b0;
    logic rho_valid;
    logic signed [W-1:0] rho_out;
    logic [11:0] rho_int;
    logic [7:0] rho_frac;
    logic done;

    int n_vec = 0;
    int n_bad = 0;

    // Behavioural model state
    int m_cos = 0, m_sin = 0, m_col = 0, m_row = 0;
    bit m_first = 1, m_done = 0, m_valid = 0;

    always #5 clk = ~clk;

    hough_ref_rho i_hough_ref_rho (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_cos_n(cfg_cos_n), .cfg_sin_n(cfg_sin_n),
        .step_valid(step_valid), .step_k(step_k),
        .row_end(row_end), .last_row(last_row),
        .rho_valid(rho_valid), .rho_out(rho_out),
        .rho_int(rho_int), .rho_frac(rho_frac), .done(done)
    );

    function automatic int wrap(input int v);
        return v & 32'h000F_FFFF;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic compare_all(input string req);
        check({req, " valid R9"}, int'(rho_valid), int'(m_valid));
        check({req, " done R8"}, int'(done), int'(m_done));
        check({req, " rho"}, int'(rho_out) & 32'hFFFFF, m_col);
        check("R7 int", int'(rho_int), (m_col >> 8) & 12'hFFF);
        check("R7 frac", int'(rho_frac), m_col & 8'hFF);
    endtask

    // One cycle: drive on falling edge, model at rising edge, compare after it.
    task automatic cyc(input string req, input bit st, input int cs, input int sn,
                       input bit sv, input int k, input bit re, input bit lr);
        bit acc, adv;
        int base;
        @(negedge clk);
        start = st; cfg_cos_n = cs[W-1:0]; cfg_sin_n = sn[W-1:0];
        step_valid = sv; step_k = k[3:0]; row_end = re; last_row = lr;
        @(posedge clk);
        acc = sv && !st && !m_done;
        adv = re && !st && !m_done;
        if (st) begin
            m_cos = cs; m_sin = sn; m_col = 0; m_row = 0;
            m_first = 1; m_done = 0;
        end else begin
            base = m_first ? m_row : m_col;
            if (acc) m_col = wrap(base + k * m_cos);
            if (adv) m_row = wrap(m_row + m_sin);
            if (adv && lr) m_done = 1;
            if (adv) m_first = 1;
            else if (acc) m_first = 0;
        end
        m_valid = acc;
        #1;
        compare_all(req);
    endtask

    initial begin : watchdog
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        compare_all("R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        compare_all("R1 after reset");

        // R2: start with cos = 1.5 blocks, sin = -0.75 blocks
        cyc("R2 start", 1, 384, -192, 0, 0, 0, 0);
        // Row 0: R4 first step from the row base, R3 steps that skip zero blocks, R12 the largest step
        cyc("R4 row0 first", 0, 0, 0, 1, 0, 0, 0);
        cyc("R3 step1", 0, 0, 0, 1, 1, 0, 0);
        cyc("R9 idle", 0, 0, 0, 0, 0, 0, 0);
        cyc("R3 skip3", 0, 0, 0, 1, 3, 0, 0);
        cyc("R12 step8", 0, 0, 0, 1, 8, 0, 0);
        cyc("R3 zero", 0, 0, 0, 1, 0, 0, 0);
        cyc("R5 row end", 0, 0, 0, 0, 0, 1, 0);
        // R6: configuration changes after start are ignored
        cyc("R4 row1 first R6", 0, 999, 777, 1, 2, 0, 0);
        cyc("R3 row1 step R6", 0, 5, 5, 1, 5, 0, 0);
        // R5: a step in the same cycle as a row-end uses the old base
        cyc("R5 step+end", 0, 0, 0, 1, 4, 1, 0);
        cyc("R4 row2 first", 0, 0, 0, 1, 7, 0, 0);
        cyc("R5 row end", 0, 0, 0, 0, 0, 1, 0);
        cyc("R4 row3 first", 0, 0, 0, 1, 1, 0, 0);
        // R8: the last row ends
        cyc("R8 last", 0, 0, 0, 0, 0, 1, 1);
        cyc("R8 step ignored", 0, 0, 0, 1, 6, 0, 0);
        cyc("R8 end ignored", 0, 0, 0, 0, 0, 1, 1);
        // R11: start takes priority over a step in the same cycle
        cyc("R11 start+step", 1, 512000, 300000, 1, 8, 1, 0);
        // R10: large terms wrap modulo 2^20
        cyc("R10 wrap a", 0, 0, 0, 1, 8, 0, 0);
        cyc("R10 wrap b", 0, 0, 0, 1, 7, 0, 0);
        cyc("R10 row wrap", 0, 0, 0, 0, 0, 1, 0);
        cyc("R10 row wrap", 0, 0, 0, 0, 0, 1, 0);
        cyc("R10 row wrap", 0, 0, 0, 0, 0, 1, 0);
        cyc("R4 R10 first", 0, 0, 0, 1, 3, 0, 0);
        // R2: a second start clears the state, negative cosine
        cyc("R2 restart", 1, -100, 50, 0, 0, 0, 0);
        cyc("R2 first", 0, 0, 0, 1, 2, 0, 0);
        cyc("R3 neg", 0, 0, 0, 1, 6, 0, 0);
        cyc("R8 last2", 0, 0, 0, 0, 0, 1, 1);
        cyc("R9 idle", 0, 0, 0, 0, 0, 0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule